// File: doc/BRIEF.md
# SD/MMC Command Sequencer with Response Capture

This block runs one card command from start to finish. Software writes a 6-bit command index, a 32-bit argument in two 16-bit halves, the block length and block count, and a command/data control word. It then starts the card clock through a start/stop control register. A command becomes pending whenever the control word is written. The block issues it on a card-side request handshake once the clock runs and the stop-transfer bit of the control word is clear. Until then the command waits.

When the card side returns a response, the block compares the received length with the response type chosen in the control word. A response that is long enough sets the end-of-response status flag. The response bytes are packed pairwise into a 9-entry, 16-bit response FIFO, which software drains one entry per read. A response that is too short sets the response-timeout flag. The block pulses an end-of-command request for every response. When data is enabled, it keeps the transfer active and presents the transfer byte count, which is block count times block length, to the data stage that follows.

Register word addresses: 0 clock control, 1 status, 2 control word, 3 command index, 4 argument high, 5 argument low, 6 block length, 7 block count, 8 response FIFO.

Top module: `sdcmd_issuer`

## Requirements
- R1: The command index register keeps its low 6 bits. A read of it returns those bits with bit 6 forced to one.
- R2: The argument high register supplies bits 31:16 and the argument low register supplies bits 15:0 of the argument presented on `cardArg`. Both registers read back as written.
- R3: A write of the control word stores the value ANDed with 0x3DFF, so bit 9 and bits 15:14 read back as zero. Within the stored word, bits 1:0 are the response type, bit 2 is data enable and bit 10 is stop-transfer.
- R4: A control-word write makes a command pending. A pending command is issued only while the clock is enabled and stop-transfer is clear. `cardReqValid` rises on the second rising edge after the write or clock-start that satisfies the last condition.
- R5: Writing clock control with bit 1 set and bit 0 clear sets status bit 8. Writing it with bit 0 set clears status bit 8 and ends any active transfer, and bit 0 takes priority when both bits are set.
- R6: `cardReqValid` stays high with a stable command and argument until `cardReqReady` is seen. No new request is made until the response for the current one arrives.
- R7: Response types 1 and 3 need at least 4 bytes and type 2 needs 16 bytes. Type 0 always completes. A shorter response sets status bit 1, clears the transfer and zeroes the response FIFO.
- R8: A good response sets status bit 13. FIFO entry i then holds byte 2i in bits 7:0 and byte 2i+1 in bits 15:8, where byte k is `cardRespData[8k+7:8k]`, and any byte at or beyond the received length reads as zero.
- R9: Each response-FIFO read returns the next of the 9 entries. Reads after the ninth return zero, and the read position returns to entry 0 at each good response.
- R10: After a good response with data enable set on an active transfer, `dataActive` stays high and `dataByteCount` equals block count (16 bits) times block length (12 bits). Without data enable, `dataActive` drops.
- R11: `endCmdPulse` is high for exactly one cycle, on the cycle after each response handshake, whether the response was good or short.
- R12: A control-word write ends any active transfer. When its stop-transfer bit is clear, it also clears status bits 1 and 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (advances the response FIFO) |
| regAddr | input | 4 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, valid in the cycle of the read strobe |
| cardReqValid | output | 1 | Command request to the card side |
| cardReqReady | input | 1 | Card side accepts the request |
| cardCmd | output | 6 | Command index of the request |
| cardArg | output | 32 | Argument of the request |
| cardRespValid | input | 1 | Response returned (one-cycle) |
| cardRespLen | input | 5 | Number of response bytes returned |
| cardRespData | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| endCmdPulse | output | 1 | End-of-command request pulse |
| dataActive | output | 1 | Data transfer active |
| dataByteCount | output | 28 | Bytes to transfer for the data stage |

## Verification
A register write shows on a read in the cycle after its write edge. A request appears on the second edge after the enabling write. Status, FIFO contents, `dataActive` and `dataByteCount` change on the edge that accepts the response, and `endCmdPulse` is high only in the cycle that follows that edge. The bench drives inputs at falling edges and samples outputs at the next falling edge, or shortly after one. Each check therefore lands exactly one or two edges after its stimulus, as those latencies predict. Read results go through a scoreboard queue, and the monitor compares each one in the cycle of its read strobe, before the FIFO advances.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int REG_DW = 16;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    ADR_CLOCK  = 4'd0,
    ADR_STATUS = 4'd1,
    ADR_CTRL   = 4'd2,
    ADR_CMDIDX = 4'd3,
    ADR_ARGHI  = 4'd4,
    ADR_ARGLO  = 4'd5,
    ADR_BLKLEN = 4'd6,
    ADR_BLKCNT = 4'd7,
    ADR_RESP   = 4'd8
  } regAddrE;

  localparam logic [REG_DW-1:0] CTRL_KEEP_MASK = 16'h3DFF;
  localparam int CTRL_DATA_BIT  = 2;
  localparam int CTRL_STOP_BIT  = 10;
  localparam int ST_TOUT_BIT    = 1;
  localparam int ST_CLK_BIT     = 8;
  localparam int ST_END_BIT     = 13;
  localparam int CLK_STOP_BIT   = 0;
  localparam int CLK_START_BIT  = 1;
  localparam logic [REG_DW-1:0] CMD_READ_FLAG = 16'h0040;

  typedef struct packed {
    logic loadResp;
    logic timeoutResp;
    logic loadCount;
  } dpStrobeT;
endpackage

// File: rtl/sdcmd_ctrl.sv
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int RESP_BYTES  = 16,
  parameter int SHORT_BYTES = 4,
  localparam int LEN_W      = $clog2(RESP_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic [1:0]        respType,
  input  logic              dataEn,
  input  logic              stopTran,
  output logic              cardReqValid,
  input  logic              cardReqReady,
  input  logic              cardRespValid,
  input  logic [LEN_W-1:0]  cardRespLen,
  output dpStrobeT          strobe,
  output logic [REG_DW-1:0] statusWord,
  output logic              dataActive,
  output logic              endCmdPulse
);
  localparam logic [LEN_W-1:0] SHORT_LEN = LEN_W'(SHORT_BYTES);
  localparam logic [LEN_W-1:0] LONG_LEN  = LEN_W'(RESP_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} stateE;

  stateE state;
  logic  pending, clkEn, stTimeout, stEndRes;
  logic  wrClk, wrCtrl, startHit, stopHit, issueGo, respArrive, respOk;

  assign wrClk    = regWrEn && (regAddr == ADR_CLOCK);
  assign wrCtrl   = regWrEn && (regAddr == ADR_CTRL);
  assign stopHit  = wrClk && regWrData[CLK_STOP_BIT];
  assign startHit = wrClk && regWrData[CLK_START_BIT] && !regWrData[CLK_STOP_BIT];
  assign issueGo  = (state == S_IDLE) && pending && clkEn && !stopTran && !wrCtrl && !stopHit;
  assign respArrive = (state == S_WAIT) && cardRespValid;

  always_comb begin
    case (respType)
      2'd0:    respOk = 1'b1;
      2'd2:    respOk = (cardRespLen >= LONG_LEN);
      default: respOk = (cardRespLen >= SHORT_LEN);
    endcase
  end

  always_comb begin
    strobe.loadResp    = respArrive && respOk;
    strobe.timeoutResp = respArrive && !respOk;
    strobe.loadCount   = respArrive && respOk && dataEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      pending     <= 1'b0;
      clkEn       <= 1'b0;
      stTimeout   <= 1'b0;
      stEndRes    <= 1'b0;
      dataActive  <= 1'b0;
      endCmdPulse <= 1'b0;
    end else begin
      endCmdPulse <= respArrive;
      case (state)
        S_IDLE: if (issueGo) state <= S_REQ;
        S_REQ:  if (cardReqReady) state <= S_WAIT;
        S_WAIT: if (cardRespValid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (issueGo) begin
        pending    <= 1'b0;
        dataActive <= 1'b1;
        stTimeout  <= 1'b0;
        stEndRes   <= 1'b0;
      end
      if (respArrive) begin
        if (respOk) begin
          stEndRes   <= 1'b1;
          stTimeout  <= 1'b0;
          dataActive <= dataActive && dataEn;
        end else begin
          stTimeout  <= 1'b1;
          dataActive <= 1'b0;
        end
      end
      if (wrCtrl) begin
        pending    <= 1'b1;
        dataActive <= 1'b0;
        if (!regWrData[CTRL_STOP_BIT]) begin
          stTimeout <= 1'b0;
          stEndRes  <= 1'b0;
        end
      end
      if (startHit) clkEn <= 1'b1;
      if (stopHit) begin
        clkEn      <= 1'b0;
        dataActive <= 1'b0;
      end
    end
  end

  assign cardReqValid = (state == S_REQ);

  always_comb begin
    statusWord              = '0;
    statusWord[ST_TOUT_BIT] = stTimeout;
    statusWord[ST_CLK_BIT]  = clkEn;
    statusWord[ST_END_BIT]  = stEndRes;
  end

  // R6: request held until accepted
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    cardReqValid && !cardReqReady |=> cardReqValid);
  // R4: a request only starts with the clock on and stop-transfer clear
  a_r4_issue_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardReqValid) |-> $past(clkEn) && !$past(stopTran));
  // R7: timeout and end-of-response never reported together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stTimeout && stEndRes));
  // R11: end pulse only follows a response handshake
  a_r11_pulse_source: assert property (@(posedge clk) disable iff (!rstN)
    endCmdPulse |-> $past(cardRespValid));
  // R5: a stop write turns the clock off and ends the transfer
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopHit) |-> !clkEn && !dataActive);
endmodule

// File: rtl/sdcmd_dp.sv
module sdcmd_dp
  import sdcmd_pkg::*;
#(
  parameter int CMD_W       = 6,
  parameter int BLKLEN_W    = 12,
  parameter int BLKCNT_W    = 16,
  parameter int RESP_BYTES  = 16,
  parameter int NUM_ENTRIES = 9,
  localparam int LEN_W      = $clog2(RESP_BYTES + 1),
  localparam int IDX_W      = $clog2(NUM_ENTRIES + 1),
  localparam int CNT_W      = BLKLEN_W + BLKCNT_W,
  localparam int ARG_W      = 2 * REG_DW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [REG_DW-1:0]     regWrData,
  output logic [REG_DW-1:0]     regRdData,
  input  dpStrobeT              strobe,
  input  logic [REG_DW-1:0]     statusWord,
  input  logic [LEN_W-1:0]      cardRespLen,
  input  logic [8*RESP_BYTES-1:0] cardRespData,
  output logic [1:0]            respType,
  output logic                  dataEn,
  output logic                  stopTran,
  output logic [CMD_W-1:0]      cardCmd,
  output logic [ARG_W-1:0]      cardArg,
  output logic [CNT_W-1:0]      dataByteCount
);
  logic [REG_DW-1:0]   ctrlWord;
  logic [CMD_W-1:0]    cmdIdx;
  logic [ARG_W-1:0]    argWord;
  logic [BLKLEN_W-1:0] blkLen;
  logic [BLKCNT_W-1:0] blkCnt;
  logic [REG_DW-1:0]   respFifo [NUM_ENTRIES];
  logic [IDX_W-1:0]    rdIdx;
  logic                rdResp;

  assign rdResp = regRdEn && (regAddr == ADR_RESP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      cmdIdx   <= '0;
      argWord  <= '0;
      blkLen   <= '0;
      blkCnt   <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADR_CTRL:   ctrlWord <= regWrData & CTRL_KEEP_MASK;
        ADR_CMDIDX: cmdIdx   <= regWrData[CMD_W-1:0];
        ADR_ARGHI:  argWord[ARG_W-1:REG_DW] <= regWrData;
        ADR_ARGLO:  argWord[REG_DW-1:0]     <= regWrData;
        ADR_BLKLEN: blkLen   <= regWrData[BLKLEN_W-1:0];
        ADR_BLKCNT: blkCnt   <= regWrData[BLKCNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [7:0] loByte, hiByte;
    if (2 * i + 1 < RESP_BYTES) begin : g_full
      localparam logic [LEN_W-1:0] LO_POS = LEN_W'(2 * i);
      localparam logic [LEN_W-1:0] HI_POS = LEN_W'(2 * i + 1);
      assign loByte = (LO_POS < cardRespLen) ? cardRespData[16*i +: 8] : 8'h00;
      assign hiByte = (HI_POS < cardRespLen) ? cardRespData[16*i+8 +: 8] : 8'h00;
    end else begin : g_empty
      assign loByte = 8'h00;
      assign hiByte = 8'h00;
    end
    always_ff @(posedge clk) begin
      if (!rstN || strobe.timeoutResp) respFifo[i] <= '0;
      else if (strobe.loadResp)         respFifo[i] <= {hiByte, loByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdIdx <= IDX_W'(NUM_ENTRIES);
    else if (strobe.loadResp) rdIdx <= '0;
    else if (rdResp && (rdIdx < IDX_W'(NUM_ENTRIES))) rdIdx <= rdIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dataByteCount <= '0;
    else if (strobe.loadCount) dataByteCount <= CNT_W'(blkCnt) * CNT_W'(blkLen);
  end

  always_comb begin
    case (regAddr)
      ADR_STATUS: regRdData = statusWord;
      ADR_CTRL:   regRdData = ctrlWord;
      ADR_CMDIDX: regRdData = REG_DW'(cmdIdx) | CMD_READ_FLAG;
      ADR_ARGHI:  regRdData = argWord[ARG_W-1:REG_DW];
      ADR_ARGLO:  regRdData = argWord[REG_DW-1:0];
      ADR_BLKLEN: regRdData = REG_DW'(blkLen);
      ADR_BLKCNT: regRdData = REG_DW'(blkCnt);
      ADR_RESP:   regRdData = (rdIdx < IDX_W'(NUM_ENTRIES)) ? respFifo[rdIdx] : '0;
      default:    regRdData = '0;
    endcase
  end

  assign respType = ctrlWord[1:0];
  assign dataEn   = ctrlWord[CTRL_DATA_BIT];
  assign stopTran = ctrlWord[CTRL_STOP_BIT];
  assign cardCmd  = cmdIdx;
  assign cardArg  = argWord;

  // R9: read position never passes the end of the FIFO
  a_r9_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    rdIdx <= IDX_W'(NUM_ENTRIES));
  // R7: a short response leaves the FIFO zeroed
  a_r7_fifo_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.timeoutResp) |-> (respFifo[0] == '0));
  // R9: a good response rewinds the read position
  a_r9_rewind: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.loadResp) |-> (rdIdx == '0));
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int CMD_W       = 6,
  parameter int BLKLEN_W    = 12,
  parameter int BLKCNT_W    = 16,
  parameter int RESP_BYTES  = 16,
  parameter int NUM_ENTRIES = 9,
  localparam int LEN_W      = $clog2(RESP_BYTES + 1),
  localparam int CNT_W      = BLKLEN_W + BLKCNT_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [REG_DW-1:0]       regWrData,
  output logic [REG_DW-1:0]       regRdData,
  output logic                    cardReqValid,
  input  logic                    cardReqReady,
  output logic [CMD_W-1:0]        cardCmd,
  output logic [2*REG_DW-1:0]     cardArg,
  input  logic                    cardRespValid,
  input  logic [LEN_W-1:0]        cardRespLen,
  input  logic [8*RESP_BYTES-1:0] cardRespData,
  output logic                    endCmdPulse,
  output logic                    dataActive,
  output logic [CNT_W-1:0]        dataByteCount
);
  dpStrobeT          strobe;
  logic [REG_DW-1:0] statusWord;
  logic [1:0]        respType;
  logic              dataEn, stopTran;

  sdcmd_ctrl #(.RESP_BYTES(RESP_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .respType(respType), .dataEn(dataEn), .stopTran(stopTran),
    .cardReqValid(cardReqValid), .cardReqReady(cardReqReady),
    .cardRespValid(cardRespValid), .cardRespLen(cardRespLen),
    .strobe(strobe), .statusWord(statusWord), .dataActive(dataActive),
    .endCmdPulse(endCmdPulse)
  );

  sdcmd_dp #(
    .CMD_W(CMD_W), .BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W),
    .RESP_BYTES(RESP_BYTES), .NUM_ENTRIES(NUM_ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe), .statusWord(statusWord),
    .cardRespLen(cardRespLen), .cardRespData(cardRespData),
    .respType(respType), .dataEn(dataEn), .stopTran(stopTran),
    .cardCmd(cardCmd), .cardArg(cardArg), .dataByteCount(dataByteCount)
  );
endmodule

// File: tb/sdcmd_issuer_test.sv
module sdcmd_issuer_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [15:0]  regWrData = '0;
  logic [15:0]  regRdData;
  logic         cardReqValid, cardReqReady = 1'b0;
  logic [5:0]   cardCmd;
  logic [31:0]  cardArg;
  logic         cardRespValid = 1'b0;
  logic [4:0]   cardRespLen = '0;
  logic [127:0] cardRespData = '0;
  logic         endCmdPulse, dataActive;
  logic [27:0]  dataByteCount;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  event        sampleEv;

  always #5 clk = ~clk;

  sdcmd_issuer uut (.*);

  task automatic checkEq(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard while the read strobe is up
  always @(sampleEv) begin
    if (expQ.size() == 0) begin
      checkEq(regRdData, 16'hxxxx, "scoreboard empty");
    end else begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkEq({16'h0, regRdData}, {16'h0, e}, t);
    end
  end

  task automatic regWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expectRead(input logic [3:0] a, input logic [15:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 -> sampleEv;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  function automatic logic [15:0] expEntry(input int i, input int len);
    logic [7:0] lo, hi;
    lo = (2*i < len && 2*i < 16) ? 8'(8'h30 + 2*i) : 8'h00;
    hi = (2*i+1 < len && 2*i+1 < 16) ? 8'(8'h31 + 2*i) : 8'h00;
    return {hi, lo};
  endfunction

  // called right after the enabling write has returned
  task automatic issueAndServe(input int len, input logic [5:0] eCmd, input logic [31:0] eArg,
                               input string tag);
    checkEq(cardReqValid, 1'b0, {"R4 no request one edge after ", tag});
    @(negedge clk);
    checkEq(cardReqValid, 1'b1, {"R4 request two edges after ", tag});
    checkEq(cardCmd, eCmd, "R1 command index on card side");
    checkEq(cardArg, eArg, "R2 argument halves on card side");
    @(negedge clk);
    checkEq(cardReqValid, 1'b1, "R6 request held without ready");
    cardReqReady = 1'b1;
    @(negedge clk);
    cardReqReady = 1'b0;
    checkEq(cardReqValid, 1'b0, "R6 request dropped after ready");
    @(negedge clk);
    checkEq(endCmdPulse, 1'b0, "R11 no pulse before response");
    cardRespValid = 1'b1; cardRespLen = 5'(len);
    @(negedge clk);
    cardRespValid = 1'b0;
    checkEq(endCmdPulse, 1'b1, "R11 pulse after response");
    @(negedge clk);
    checkEq(endCmdPulse, 1'b0, "R11 pulse lasts one cycle");
    checkEq(cardReqValid, 1'b0, "R6 no reissue after response");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 16; k++) cardRespData[8*k +: 8] = 8'(8'h30 + k);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq(cardReqValid, 1'b0, "R4 reset no request");
    checkEq(dataActive, 1'b0, "R10 reset inactive");
    expectRead(4'd1, 16'h0000, "R5 reset status");

    regWrite(4'd3, 16'h00FF);
    expectRead(4'd3, 16'h007F, "R1 index width and flag");
    regWrite(4'd3, 16'h0005);
    expectRead(4'd3, 16'h0045, "R1 index flag set");
    regWrite(4'd4, 16'h1234);
    regWrite(4'd5, 16'hABCD);
    expectRead(4'd4, 16'h1234, "R2 high half");
    expectRead(4'd5, 16'hABCD, "R2 low half");
    regWrite(4'd6, 16'hF200);
    regWrite(4'd7, 16'h0003);

    // stop-transfer set: pending but never issued
    regWrite(4'd2, 16'hFFFF);
    expectRead(4'd2, 16'h3DFF, "R3 control mask");
    regWrite(4'd0, 16'h0002);
    expectRead(4'd1, 16'h0100, "R5 clock on");
    repeat (2) @(negedge clk);
    checkEq(cardReqValid, 1'b0, "R4 stop-transfer holds command");

    // short response type 1, 6 bytes
    regWrite(4'd2, 16'h0001);
    issueAndServe(6, 6'd5, 32'h1234ABCD, "control write");
    expectRead(4'd1, 16'h2100, "R8 end-of-response status");
    checkEq(dataActive, 1'b0, "R10 inactive without data enable");
    expectRead(4'd8, expEntry(0, 6), "R8 entry 0 packing");
    expectRead(4'd8, expEntry(1, 6), "R8 entry 1 packing");

    // long type with 15 bytes: timeout
    regWrite(4'd2, 16'h0002);
    issueAndServe(15, 6'd5, 32'h1234ABCD, "control write");
    expectRead(4'd1, 16'h0102, "R7 long response timeout");
    checkEq(dataActive, 1'b0, "R7 timeout ends transfer");

    // long type with data enable
    regWrite(4'd2, 16'h0006);
    issueAndServe(16, 6'd5, 32'h1234ABCD, "control write");
    expectRead(4'd1, 16'h2100, "R7 long response complete");
    checkEq(dataActive, 1'b1, "R10 transfer stays active");
    checkEq(dataByteCount, 28'h600, "R10 byte count");
    for (int i = 0; i < 9; i++) expectRead(4'd8, expEntry(i, 16), "R9 entry sequence");
    expectRead(4'd8, 16'h0000, "R9 read past end");

    regWrite(4'd0, 16'h0001);
    checkEq(dataActive, 1'b0, "R5 clock stop ends transfer");
    expectRead(4'd1, 16'h2000, "R5 clock off status");
    regWrite(4'd0, 16'h0002);
    @(negedge clk);
    checkEq(cardReqValid, 1'b0, "R4 no pending after issue");

    regWrite(4'd2, 16'h0006);
    issueAndServe(16, 6'd5, 32'h1234ABCD, "control write");
    checkEq(dataActive, 1'b1, "R10 active again");
    regWrite(4'd2, 16'h0400);
    checkEq(dataActive, 1'b0, "R12 control write ends transfer");
    expectRead(4'd1, 16'h2100, "R12 stop-set write keeps status");
    checkEq(cardReqValid, 1'b0, "R4 stop-set write no request");

    // clock off, command waits for clock start
    regWrite(4'd0, 16'h0001);
    regWrite(4'd2, 16'h0003);
    expectRead(4'd1, 16'h0000, "R12 status cleared");
    repeat (2) @(negedge clk);
    checkEq(cardReqValid, 1'b0, "R4 clock off holds command");
    regWrite(4'd0, 16'h0002);
    issueAndServe(4, 6'd5, 32'h1234ABCD, "clock start");
    expectRead(4'd1, 16'h2100, "R7 type 3 with 4 bytes");

    regWrite(4'd2, 16'h0000);
    issueAndServe(0, 6'd5, 32'h1234ABCD, "control write");
    expectRead(4'd1, 16'h2100, "R7 no-response type completes");
    expectRead(4'd8, 16'h0000, "R8 empty response zeroed");

    regWrite(4'd2, 16'h0003);
    issueAndServe(3, 6'd5, 32'h1234ABCD, "control write");
    expectRead(4'd1, 16'h0102, "R7 short response timeout");

    regWrite(4'd0, 16'h0003);
    expectRead(4'd1, 16'h0002, "R5 stop wins over start");

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule